// File: doc/BRIEF.md
# Distributed Rotating-Priority Bus Arbiter Node

One copy of this block sits in each processor that shares a common external bus with up to seven peers and a host. Every copy samples the same eight processor request lines, the host request, and the shared lock signal on the same clock edge. Because all copies run the same deterministic next-owner computation, they agree on the owner without any central arbiter. Each copy asserts its own local grant only when the chosen owner's ID equals the node ID it was built with.

Among the processors, priority rotates. After a processor wins, the ID just above it becomes the first candidate, and IDs wrap from the top back to zero. A tenure counter bounds how long an owner may keep the bus while others are waiting. The shared lock freezes the current owner so that a read-modify-write sequence stays whole. The host has its own grant output. When the host holds the bus, no processor is granted.

Top module: `bus_arb_node`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `node_grant`, `host_grant` and `owner_valid` are 0, whatever the request inputs are.
- R2: Bit i of `bus_req` is the request of processor ID i, and `owner_id` carries the owner's ID in binary. `node_grant` is 1 exactly when `owner_valid` is 1 and `owner_id` equals the node's `MY_ID` parameter. Copies with different IDs report the same `owner_id`.
- R3: At a tenure boundary, the next processor owner is the first requester found when searching upward from (previous winner + 1), wrapping from ID 7 to ID 0. After reset the search starts at ID 0. A host tenure does not move this starting point.
- R4: An owner whose request stays high keeps the bus when no other processor or host request is pending, for any length of time.
- R5: When other requests are pending, a processor owner keeps the bus for exactly `tenure_limit` cycles of `owner_valid`. It is then replaced by rotation and excluded from that arbitration.
- R6: While `bus_lock` is high, the current processor owner stays the owner. This holds even if its request drops or its tenure limit has passed.
- R7: A pending `host_req` wins over every processor at a tenure boundary when `bus_lock` is low. While `host_grant` is 1, `owner_valid` and `node_grant` are 0. The host keeps the bus until `host_req` falls.
- R8: While a locked processor owner holds the bus, `host_grant` stays 0 even if `host_req` is high.
- R9: When `host_req` falls, the processors re-arbitrate on the next clock edge, using the priority starting point that was in force before the host tenure.
- R10: A tenure ends when the owner's request falls. If no request is pending at that point, the bus goes idle (`owner_valid` = 0) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NODES | Processor bus requests, bit i = ID i |
| bus_lock | input | 1 | Shared lock held by the current owner |
| host_req | input | 1 | Host bus request |
| tenure_limit | input | TENURE_W | Fairness tenure length in cycles |
| node_grant | output | 1 | This node owns the bus (registered) |
| host_grant | output | 1 | Host owns the bus (registered) |
| owner_valid | output | 1 | Some processor owns the bus |
| owner_id | output | ID_W | ID of the current processor owner |

## Verification
Every result is due one clock edge after the inputs that cause it. The request, lock and host inputs are sampled on an edge, the next-owner decision is computed combinationally, and all four outputs are registered on that same edge. The bench therefore drives inputs just after a falling edge and checks outputs at the next falling edge. Fairness sequences are checked once per cycle, so each owner must be seen exactly `tenure_limit` times in a row. Two node copies with different IDs are compared to confirm that they agree on the owner and that their local grants are exclusive.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int DEF_NODES    = 8;
  localparam int DEF_TENURE_W = 4;

  function automatic int wrap_next(input int id, input int nodes);
    return (id + 1 >= nodes) ? 0 : id + 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NODES = 8,
  localparam int ID_W = $clog2(NODES)
) (
  input  logic [NODES-1:0] elig,
  input  logic [ID_W-1:0]  start,
  output logic             found,
  output logic [ID_W-1:0]  win
);
  // Scan from start upward with wrap; the candidate closest to start wins.
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      int idx;
      idx = int'(start) + i;
      if (idx >= NODES) idx = idx - NODES;
      if (elig[idx]) begin
        found = 1'b1;
        win   = ID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/tenure_timer.sv
module tenure_timer #(
  parameter int TENURE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [TENURE_W-1:0] limit,
  output logic                done
);
  logic [TENURE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= TENURE_W'(1);
    else if (cnt != '1)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= limit);

  // R5: the counter saturates instead of wrapping back below the limit
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1 && !load) |=> (cnt == '1));
endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node #(
  parameter int NODES    = bus_arb_pkg::DEF_NODES,
  parameter int TENURE_W = bus_arb_pkg::DEF_TENURE_W,
  parameter int MY_ID    = 0,
  localparam int ID_W    = $clog2(NODES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NODES-1:0]    bus_req,
  input  logic                bus_lock,
  input  logic                host_req,
  input  logic [TENURE_W-1:0] tenure_limit,
  output logic                node_grant,
  output logic                host_grant,
  output logic                owner_valid,
  output logic [ID_W-1:0]     owner_id
);
  logic            cur_valid, host_act;
  logic [ID_W-1:0] cur_id, prio;

  logic            n_valid, n_host, load_t, tenure_done;
  logic [ID_W-1:0] n_id, n_prio;
  logic [NODES-1:0] own_bit, elig;
  logic            others, proc_end, host_end, boundary, found;
  logic [ID_W-1:0] win;

  always_comb begin
    own_bit = '0;
    if (cur_valid) own_bit[cur_id] = 1'b1;
  end

  assign elig     = bus_req & ~own_bit;
  assign others   = (|elig) | host_req;
  assign proc_end = cur_valid && !bus_lock &&
                    (!bus_req[cur_id] || (tenure_done && others));
  assign host_end = host_act && !host_req;
  assign boundary = (!cur_valid && !host_act) || proc_end || host_end;

  rr_pick #(.NODES(NODES)) u_pick (
    .elig  (elig),
    .start (prio),
    .found (found),
    .win   (win)
  );

  tenure_timer #(.TENURE_W(TENURE_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (load_t),
    .limit (tenure_limit),
    .done  (tenure_done)
  );

  always_comb begin
    n_valid = cur_valid;
    n_host  = host_act;
    n_id    = cur_id;
    n_prio  = prio;
    load_t  = 1'b0;
    if (boundary) begin
      if (host_req && !bus_lock) begin
        n_host  = 1'b1;
        n_valid = 1'b0;
      end else if (found) begin
        n_host  = 1'b0;
        n_valid = 1'b1;
        n_id    = win;
        n_prio  = ID_W'(bus_arb_pkg::wrap_next(int'(win), NODES));
        load_t  = 1'b1;
      end else begin
        n_host  = 1'b0;
        n_valid = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid  <= 1'b0;
      host_act   <= 1'b0;
      cur_id     <= '0;
      prio       <= '0;
      node_grant <= 1'b0;
    end else begin
      cur_valid  <= n_valid;
      host_act   <= n_host;
      cur_id     <= n_id;
      prio       <= n_prio;
      node_grant <= n_valid && (n_id == ID_W'(MY_ID));
    end
  end

  assign host_grant  = host_act;
  assign owner_valid = cur_valid;
  assign owner_id    = cur_id;

  // R4: a requesting owner inside its tenure is never displaced
  p_hold_req_r4: assert property (@(posedge clk) disable iff (rst)
    (owner_valid && bus_req[owner_id] && !tenure_done) |=> (owner_valid && $stable(owner_id)));
  // R6: lock freezes the owner
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (owner_valid && bus_lock) |=> (owner_valid && $stable(owner_id)));
  // R7: host ownership excludes every processor grant
  p_host_excl_r7: assert property (@(posedge clk) disable iff (rst)
    host_grant |-> (!node_grant && !owner_valid));
  // R8: no host grant while a processor holds the lock
  p_host_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (owner_valid && bus_lock) |=> !host_grant);
endmodule

// File: tb/bus_arb_node_test.sv
module bus_arb_node_test;
  localparam int N  = 8;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  bus_req = '0;
  logic          bus_lock = 1'b0;
  logic          host_req = 1'b0;
  logic [TW-1:0] tenure_limit = TW'(15);
  logic          g2, g5, hg2, hg5, ov2, ov5;
  logic [2:0]    id2, id5;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_arb_node #(.NODES(N), .TENURE_W(TW), .MY_ID(2)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_lock(bus_lock),
    .host_req(host_req), .tenure_limit(tenure_limit),
    .node_grant(g2), .host_grant(hg2), .owner_valid(ov2), .owner_id(id2));

  bus_arb_node #(.NODES(N), .TENURE_W(TW), .MY_ID(5)) peer (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_lock(bus_lock),
    .host_req(host_req), .tenure_limit(tenure_limit),
    .node_grant(g5), .host_grant(hg5), .owner_valid(ov5), .owner_id(id5));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected owner: id valid (-1 = idle, -2 = host)
  task automatic chk_owner(input string tag, input int exp);
    int act;
    act = hg2 ? -2 : (ov2 ? int'(id2) : -1);
    chk(tag, act, exp);
    chk({tag, " grant2"}, int'(g2), int'(exp == 2));
    chk({tag, " grant5"}, int'(g5), int'(exp == 5));
    chk({tag, " peer agree"}, hg5 ? -2 : (ov5 ? int'(id5) : -1), exp);
  endtask

  task automatic t_reset();
    bus_req = 8'h04; host_req = 1'b1;
    tick();
    chk_owner("R1 in reset", -1);
    bus_req = '0; host_req = 1'b0;
    rst = 1'b0;
    chk_owner("R1 after reset", -1);
  endtask

  task automatic t_single();
    bus_req = 8'h04;
    tick();
    chk_owner("R2 single request", 2);
    bus_req = '0;
    tick();
    chk_owner("R10 release to idle", -1);
  endtask

  task automatic t_hold_alone();
    tenure_limit = TW'(4);
    bus_req = 8'h04;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk_owner("R4 alone holds", 2);
    end
    bus_req = '0;
    tick();
    chk_owner("R10 idle", -1);
  endtask

  task automatic t_rotate();
    tenure_limit = TW'(15);
    bus_req = 8'h42;               // IDs 1 and 6, search starts at 3
    tick();
    chk_owner("R3 rotate picks 6", 6);
    bus_req = 8'h02;
    tick();
    chk_owner("R3 wrap to 1", 1);
    bus_req = '0;
    tick();
    chk_owner("R10 idle", -1);
  endtask

  task automatic t_fair();
    int seq[7] = '{3, 3, 3, 5, 5, 5, 3};
    tenure_limit = TW'(3);
    bus_req = 8'h28;               // IDs 3 and 5, search starts at 2
    for (int i = 0; i < 7; i++) begin
      tick();
      chk_owner("R5 fairness sequence", seq[i]);
    end
    bus_req = '0;
    tick();
    chk_owner("R10 idle", -1);
  endtask

  task automatic t_lock_host();
    tenure_limit = TW'(3);
    bus_lock = 1'b1;
    bus_req = 8'h28;               // search starts at 4
    tick();
    chk_owner("R6 locked owner", 5);
    for (int i = 0; i < 5; i++) begin
      if (i == 2) host_req = 1'b1;
      tick();
      chk_owner("R6 lock beyond tenure", 5);
      chk("R8 host held off", int'(hg2), 0);
    end
    bus_req = 8'h08;
    tick();
    chk_owner("R6 lock after request drop", 5);
    bus_lock = 1'b0;
    tick();
    chk_owner("R7 host wins boundary", -2);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk_owner("R7 host holds", -2);
    end
    host_req = 1'b0;
    tick();
    chk_owner("R9 rearbitrate after host", 3);
    bus_req = '0;
    tick();
    chk_owner("R10 idle", -1);
  endtask

  initial begin
    @(negedge clk);
    tick();
    t_reset();
    t_single();
    t_hold_alone();
    t_rotate();
    t_fair();
    t_lock_host();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule